// File: doc/BRIEF.md
# Phase-accumulator clock-enable generator

The block turns one fixed system clock into a programmable-rate enable strobe, with no second clock domain. A free-running binary phase register adds an unsigned increment word on every clock cycle; the carry out of that addition is the strobe. Downstream logic stays on the system clock and qualifies its registers with the strobe, so it advances at an average rate of fclk × increment / 2^W. W is 32 by default. To pick a target rate, the user loads an increment of fout / fclk × 2^W.

The increment word is latched into a holding register on each clock edge and may be changed at any time. The phase register is never cleared on wrap, so the phase continues across a retune. An optional toggle stage, selected by a parameter, flips a square-wave output on every strobe. That output runs at half the strobe rate.

Top module: `phase_clken_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the holding register, the phase register and the toggle register are cleared to zero. After that edge, `strobe_o` and `wave_o` are both 0.
- R2: The value on `inc_i` at clock edge k is captured into the holding register at that edge. The phase register first adds it at edge k+1.
- R3: At each edge the phase register is loaded with the sum of its lower W bits and the held increment, written into all W+1 bits. `strobe_o` is the top bit (bit W) of the phase register.
- R4: When the held increment is below 2^(W-1) at two consecutive edges, a strobe that is high after the first of those edges is low after the second.
- R5: Over a window of N cycles at a constant increment `inc`, the number of strobes is within one of floor(inc × N / 2^W).
- R6: The increment is unsigned. Values at or above 2^(W-1) give the rate of R5, up to the largest value 2^W − 1.
- R7: While the held increment is zero, `strobe_o` stays low.
- R8: Changing `inc_i` while running never resets the phase. The lower W bits continue from their current value with the new increment.
- R9: With the toggle stage enabled, `wave_o` inverts at each edge where `strobe_o` was high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | PHASE_W | Unsigned phase increment, may change at any time |
| strobe_o | output | 1 | Enable strobe, the carry bit of the phase register |
| wave_o | output | 1 | Square wave that flips on each strobe (0 when the toggle stage is disabled) |

## Verification
Assertions check four properties on every cycle: the reset state, a held zero increment keeping the strobe low, the ban on back-to-back strobes below half scale, and the rule that the toggle output moves only on a strobe. Exact sum-and-carry arithmetic can only be shown against the bench's cycle model. The same holds for the one-edge capture delay and phase continuity across random retunes. The long-run rate, including increments with the top bit set and the all-ones increment, is shown only by the bench's counted windows.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam int unsigned DEF_PHASE_W = 32;

    // sum of the fractional part and the increment, one bit wider
    function automatic logic [DEF_PHASE_W:0] phase_step(
        input logic [DEF_PHASE_W-1:0] frac,
        input logic [DEF_PHASE_W-1:0] inc
    );
        return {1'b0, frac} + {1'b0, inc};
    endfunction
endpackage

// File: rtl/pce_inc_hold.sv
module pce_inc_hold #(
    parameter int unsigned W = pce_pkg::DEF_PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] inc_i,
    output logic [W-1:0] inc_q
);
    always_ff @(posedge clk) begin
        if (rst) inc_q <= '0;
        else     inc_q <= inc_i;
    end
endmodule

// File: rtl/pce_phase_acc.sv
module pce_phase_acc #(
    parameter int unsigned W = pce_pkg::DEF_PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] inc_q,
    output logic         carry_o
);
    logic [W:0]   phase_q;
    logic [W:0]   phase_d;
    logic [W-1:0] frac;

    assign frac    = phase_q[W-1:0];
    assign phase_d = {1'b0, frac} + {1'b0, inc_q};
    assign carry_o = phase_q[W];

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase_q == '0) && !carry_o);

    // R7
    zero_inc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_q == '0) |=> !carry_o);

    // R4
    no_double_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (carry_o && !inc_q[W-1] && !$past(inc_q[W-1])) |=> !carry_o);
endmodule

// File: rtl/pce_toggle.sv
module pce_toggle (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic wave_o
);
    always_ff @(posedge clk) begin
        if (rst)       wave_o <= 1'b0;
        else if (en_i) wave_o <= ~wave_o;
    end

    // R9
    wave_flip_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (wave_o != $past(wave_o)));

    // R9
    wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(wave_o));
endmodule

// File: rtl/phase_clken_gen.sv
module phase_clken_gen #(
    parameter int unsigned PHASE_W = pce_pkg::DEF_PHASE_W,
    parameter bit          WAVE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] inc_i,
    output logic               strobe_o,
    output logic               wave_o
);
    logic [PHASE_W-1:0] inc_q;

    pce_inc_hold #(.W(PHASE_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .inc_i(inc_i),
        .inc_q(inc_q)
    );

    pce_phase_acc #(.W(PHASE_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .inc_q  (inc_q),
        .carry_o(strobe_o)
    );

    generate
        if (WAVE_EN) begin : g_wave
            pce_toggle u_tog (
                .clk   (clk),
                .rst   (rst),
                .en_i  (strobe_o),
                .wave_o(wave_o)
            );
        end else begin : g_nowave
            assign wave_o = 1'b0;
        end
    endgenerate
endmodule

// File: tb/test_phase_clken_gen.sv
`timescale 1ns/1ps
module test_phase_clken_gen;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] inc_i = '0;
    logic         strobe_o, wave_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phase_clken_gen i_phase_clken_gen (
        .clk(clk), .rst(rst), .inc_i(inc_i),
        .strobe_o(strobe_o), .wave_o(wave_o)
    );

    // cycle model written from R1, R2, R3, R9
    logic [W-1:0] m_inc;
    logic [W:0]   m_acc;
    logic         m_wave;
    always @(posedge clk) begin
        if (rst) begin
            m_inc <= '0; m_acc <= '0; m_wave <= 1'b0;
        end else begin
            m_inc  <= inc_i;
            m_acc  <= {1'b0, m_acc[W-1:0]} + {1'b0, m_inc};
            m_wave <= m_wave ^ m_acc[W];
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input longint act, input longint exp);
        checks++;
        if (act > exp + 1 || act < exp - 1) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (+-1)", req, act, exp);
        end
    endtask

    function automatic longint expected_count(input logic [W-1:0] inc, input int n);
        return longint'((64'(inc) * 64'(n)) >> W);
    endfunction

    // count strobes over n cycles at a constant increment (R5)
    task automatic rate_window(input string req, input logic [W-1:0] inc, input int n);
        longint cnt = 0;
        bit dbl = 0;
        bit prev = 0;
        @(negedge clk); inc_i = inc;
        repeat (3) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (strobe_o) cnt++;
            if (strobe_o && prev) dbl = 1;
            prev = strobe_o;
        end
        check_near(req, cnt, expected_count(inc, n));
        // R4 back-to-back strobes only allowed at or above half scale
        if (!inc[W-1]) check("R4 no double strobe", dbl, 0);
    endtask

    initial begin
        int unsigned seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 strobe after reset", strobe_o, 0);
        check("R1 wave after reset", wave_o, 0);
        rst = 1'b0;

        // R2: increment applied at edge k reaches strobe only after edge k+2
        inc_i = 32'hFFFF_FFFF;
        @(negedge clk); check("R2 strobe one edge later", strobe_o, 0);
        @(negedge clk); check("R2 strobe two edges later", strobe_o, 0);
        @(negedge clk); check("R3 strobe after sum carries", strobe_o, 1);
        check("R9 wave before flip", wave_o, 0);
        @(negedge clk); check("R9 wave after strobe", wave_o, 1);

        // R3 R8 R9 random retunes against the cycle model
        for (int k = 0; k < 3000; k++) begin
            case ($urandom % 4)
                0: inc_i = $urandom;
                1: inc_i = $urandom & 32'h0FFF_FFFF;
                2: inc_i = $urandom | 32'h8000_0000;
                default: ;
            endcase
            @(negedge clk);
            check("R3 R8 strobe vs model", strobe_o, m_acc[W]);
            check("R9 wave vs model", wave_o, m_wave);
        end

        // R7 zero increment
        rate_window("R7 zero increment count", 32'h0, 2000);
        check("R7 strobe low", strobe_o, 0);
        // R5 rates below half scale
        rate_window("R5 rate 0.1", 32'h1999_999A, 4096);
        rate_window("R5 rate small", 32'h0000_7531, 8192);
        rate_window("R5 rate just below half", 32'h7FFF_FFFF, 4096);
        // R6 unsigned upper half
        rate_window("R6 rate 0.75", 32'hC000_0000, 4096);
        rate_window("R6 rate 0.8", 32'hCCCC_CCCD, 4096);
        rate_window("R6 rate max", 32'hFFFF_FFFF, 4096);

        // R1 reset mid-run
        rst = 1'b1; @(negedge clk);
        check("R1 strobe in reset", strobe_o, 0);
        check("R1 wave in reset", wave_o, 0);
        rst = 1'b0; inc_i = '0;
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule